// File: doc/BRIEF.md
# AES Column Mixer (Forward and Inverse)

This unit applies the AES column-mixing transform to a full cipher state, or the inverse of that transform. The state is taken as a set of 32-bit column words. Each column is mixed on its own and by the same function. A per-transfer mode bit selects the direction. The inverse direction does not use a separate network of 0x09/0x0B/0x0D/0x0E multipliers. Instead it puts a small conditioning step in front of the forward mixer. That step xors the column with its 16-bit rotation, doubles the result twice in GF(2^8), and folds it back into the column.

Data enters through a valid/ready handshake and leaves through one output register, which is held under back-pressure. The block is meant to sit inside a round datapath. The byte substitution, the row rotation, the key schedule and the round sequencing are all handled by its neighbours.

Byte layout: state byte i sits at bits [8i+7:8i]. It belongs to column i/4 and row i%4. Row 0 is the least significant byte of its column word.

Top module: `aes_colmix`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0.
- R2: With in_inv = 0, each output column equals the forward mix of the input column. Its output row r is 2·a[r] ^ 3·a[r+1] ^ a[r+2] ^ a[r+3] (row indices mod 4) in GF(2^8) with polynomial 0x11B. Example: input rows db 13 53 45 give 8e 4d a1 bc.
- R3: With in_inv = 1, each output column equals the inverse mix of the input column. Example: input rows 8e 4d a1 bc give db 13 53 45.
- R4: Each column's output depends only on that column's input. Changing one column leaves the other columns of the result unchanged.
- R5: A transfer accepted at a clock edge (in_valid and in_ready both high) makes out_valid high after that edge, with that transfer's result on out_data.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R7: in_ready is low exactly when out_valid is high and out_ready is low.
- R8: When out_valid and out_ready are both high and no transfer is accepted, out_valid is low after the edge.
- R9: Sending any state forward and then sending the result back inverse returns the original state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input state present |
| in_ready | output | 1 | Unit can accept an input |
| in_inv | input | 1 | 0 = forward mix, 1 = inverse mix |
| in_data | input | 32·NCOL | Input state, column j at bits [32j+31:32j] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 32·NCOL | Mixed state |

## Verification
The bench builds the unit with the default NCOL = 4, which is the full 128-bit state of the cipher. With this setting, published column vectors can be placed in every column lane at once, and in different lanes on different transfers. A wiring or indexing slip in one lane therefore shows up against known results. The same width is also used for the random forward-then-inverse round trips, which cover byte values far outside the published vectors.

// File: rtl/aes_colmix.sv
module aes_colmix #(
  parameter int NCOL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_inv,
  input  logic [32*NCOL-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [32*NCOL-1:0] out_data
);
  localparam int W = 32 * NCOL;

  function automatic logic [31:0] dbl4(input logic [31:0] w);
    logic [31:0] top;
    top  = w & 32'h8080_8080;
    dbl4 = ((w & 32'h7f7f_7f7f) << 1) ^ ((top >> 7) * 32'h1b);
  endfunction

  function automatic logic [31:0] ror8(input logic [31:0] w);
    ror8 = {w[7:0], w[31:8]};
  endfunction

  function automatic logic [31:0] ror16(input logic [31:0] w);
    ror16 = {w[15:0], w[31:16]};
  endfunction

  function automatic logic [31:0] ror24(input logic [31:0] w);
    ror24 = {w[23:0], w[31:24]};
  endfunction

  function automatic logic [31:0] fwd_mix(input logic [31:0] w);
    fwd_mix = ror8(w) ^ ror16(w) ^ ror24(w) ^ dbl4(ror8(w) ^ w);
  endfunction

  function automatic logic [31:0] inv_pre(input logic [31:0] w);
    inv_pre = w ^ dbl4(dbl4(ror16(w) ^ w));
  endfunction

  logic [W-1:0] mixed;
  logic         take;

  assign take     = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [31:0] col_in, col_pre;
    assign col_in  = in_data[32*c +: 32];
    assign col_pre = in_inv ? inv_pre(col_in) : col_in;
    assign mixed[32*c +: 32] = fwd_mix(col_pre);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= mixed;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module aes_colmix_chk #(
  parameter int NCOL = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [32*NCOL-1:0] out_data
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_valid_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_ready_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && !out_ready) |-> in_ready);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind aes_colmix aes_colmix_chk #(.NCOL(NCOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_aes_colmix.sv
module tb_aes_colmix;
  localparam int NCOL = 4;
  localparam int W = 32 * NCOL;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_inv = 0, out_ready = 1;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  aes_colmix #(.NCOL(NCOL)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_inv(in_inv), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // {inv, input state, expected state}; column 0 in the low word
  localparam logic [256:0] TBL [6] = '{
    {1'b0, 128'h4c31262d_d5d4d4d4_5c220af2_455313db, 128'hf8bd7e4d_d6d7d5d5_9d58dc9f_bca14d8e},
    {1'b0, 128'hc6c6c6c6_01010101_455313db_5c220af2, 128'hc6c6c6c6_01010101_bca14d8e_9d58dc9f},
    {1'b0, 128'h0, 128'h0},
    {1'b1, 128'hf8bd7e4d_d6d7d5d5_9d58dc9f_bca14d8e, 128'h4c31262d_d5d4d4d4_5c220af2_455313db},
    {1'b1, 128'hc6c6c6c6_01010101_bca14d8e_9d58dc9f, 128'hc6c6c6c6_01010101_455313db_5c220af2},
    {1'b1, 128'h0, 128'h0}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic inv, input logic [W-1:0] din, output logic [W-1:0] dout);
    @(negedge clk);
    in_valid = 1; in_inv = inv; in_data = din;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
    @(negedge clk);
    chk("R5 out_valid after accept", {127'b0, out_valid}, 1);
    dout = out_data;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] r, r2, x, y, a_out;
    repeat (2) @(negedge clk);
    chk("R1 out_valid in reset", {127'b0, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid after reset", {127'b0, out_valid}, 0);

    for (int i = 0; i < 6; i++) begin
      xfer(TBL[i][256], TBL[i][255:128], r);
      chk(TBL[i][256] ? "R3 inverse vector" : "R2 forward vector", r, TBL[i][127:0]);
    end

    // R4: change only column 2
    xfer(0, TBL[0][255:128], a_out);
    x = TBL[0][255:128];
    x[64 +: 32] = 32'h01010101;
    xfer(0, x, r);
    chk("R4 column 0 unaffected", {96'b0, r[31:0]}, {96'b0, a_out[31:0]});
    chk("R4 column 1 unaffected", {96'b0, r[63:32]}, {96'b0, a_out[63:32]});
    chk("R4 column 3 unaffected", {96'b0, r[127:96]}, {96'b0, a_out[127:96]});
    chk("R4 column 2 new value", {96'b0, r[95:64]}, 128'h01010101);

    // R9 round trips
    for (int k = 0; k < 8; k++) begin
      x = {$urandom, $urandom, $urandom, $urandom};
      xfer(0, x, y);
      xfer(1, y, r);
      chk("R9 round trip", r, x);
    end

    // R6/R7/R8 stall behaviour
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_inv = 0; in_data = TBL[0][255:128];
    @(posedge clk); #1;
    in_data = TBL[1][255:128];
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk("R6 held data", out_data, TBL[0][127:0]);
      chk("R6 held valid", {127'b0, out_valid}, 1);
      chk("R7 in_ready low in stall", {127'b0, in_ready}, 0);
    end
    out_ready = 1;
    #1;
    chk("R7 in_ready high when drained", {127'b0, in_ready}, 1);
    @(posedge clk); #1;
    in_valid = 0;
    @(negedge clk);
    chk("R5 next result after stall", out_data, TBL[1][127:0]);
    chk("R5 valid after stall", {127'b0, out_valid}, 1);
    @(negedge clk);
    chk("R8 valid drops when drained", {127'b0, out_valid}, 0);

    // R1 reset mid-stream
    @(negedge clk);
    in_valid = 1; in_data = TBL[2][255:128];
    @(posedge clk); #1;
    in_valid = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset clears valid", {127'b0, out_valid}, 0);
    rst_n = 1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule